// File: doc/BRIEF.md
# PHY Power-Up Sequencer with PLL Lock Retry

This block takes a high-speed serial PHY from its powered-down, isolated state to an operating state. It drives the PHY's analog control lines one step at a time: isolation, the low-leakage (IDDQ) mode, the bandgap, LDO and PLL power enables, core-ready, a power-on/power-ok handshake pair and a multi-bit port-control field. Each step holds for its own wait before the next one begins. Every wait is a microsecond count multiplied by the `CYC_PER_US` parameter and is timed by a single down-counter that is reloaded at each step.

Once the power rails are up, the block releases the PLL reset and then the PHY reset. It then samples a PLL lock input, after a two-flop synchronizer, once per microsecond. If lock is not seen within `LOCK_TRIES` samples, the PLL reset is pulsed low for one cycle and the whole polling round runs again. A second miss flags an error. Whether lock was found or not, the port-control field is set to a non-driving value, and in the next cycle `done_o` rises. A `start_i` pulse begins a run only while the block is idle.

Top module: `phy_pwrup_seq`

## Requirements
- R1: While reset is asserted and after it is released, iso_o=1 and every other control line is 0: iddq, bandgap, PLL and LDO enables, core-ready, power-on, power-ok, both active-low resets. pctl_o=0 and busy_o, done_o and err_o are 0.
- R2: A start_i seen high while idle sets busy_o in the next cycle and returns all controls to the R1 values. iddq_o then rises exactly 10·CYC_PER_US cycles after the accepting edge.
- R3: The steps and the waits from each rise to the next are fixed:
  - iddq rise to core-ready rise: 170 us. This covers a 10 us hold, then a 160 us quiet step in which the bandgap, PLL and LDO enables and core-ready are driven low and pctl_o is set to PCTL_PWRUP.
  - core-ready to bandgap enable: 50 us.
  - bandgap enable to LDO enable: 200 us.
  - LDO enable to power-ok: 10 us.
  - power-ok to PLL enable: 10 us.
- R4: LDO enable and power-on rise on the same edge. Isolation falls 10 us after the PLL enable rose, and only while the PLL enable is high. iddq falls 10 us after isolation falls.
- R5: pll_rst_n_o rises 1 us after iddq falls. phy_rst_n_o rises exactly one cycle later.
- R6: Lock is sampled through a two-flop synchronizer every CYC_PER_US cycles, with the first sample CYC_PER_US cycles after the PHY reset release. A high sample ends the round: pctl_o changes on that edge and done_o rises one cycle later with err_o=0. If none of LOCK_TRIES samples is high, pll_rst_n_o falls LOCK_TRIES·CYC_PER_US cycles after the PHY reset release.
- R7: The retry pulse holds pll_rst_n_o low for exactly one cycle while phy_rst_n_o stays high. A second polling round follows, and lock found in that round ends with err_o=0.
- R8: If the second round also misses lock, err_o=1 together with done_o.
- R9: pctl_o equals PCTL_HIZ in the cycle before done_o rises, after both a pass and a failure.
- R10: start_i while busy_o=1 is ignored: the step timing of the run in progress is unchanged.
- R11: done_o and err_o hold with busy_o=0 until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a power-up run (taken only when idle) |
| pll_lock_i | input | 1 | PLL lock indication, asynchronous |
| iso_o | output | 1 | PHY isolation |
| iddq_o | output | 1 | PHY low-leakage mode |
| bg_en_o | output | 1 | Bandgap power enable |
| pll_en_o | output | 1 | PLL power enable |
| ldo_en_o | output | 1 | LDO power enable |
| core_rdy_o | output | 1 | Core-ready indication to the PHY |
| pwr_on_o | output | 1 | Power-on handshake |
| pwr_ok_o | output | 1 | Power-ok handshake |
| pll_rst_n_o | output | 1 | PLL reset, active low |
| phy_rst_n_o | output | 1 | PHY reset, active low |
| pctl_o | output | PCTL_W | Port-control field |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Run finished |
| err_o | output | 1 | Run finished without PLL lock |

## Verification
The assertions assume only that rst_n is held low long enough for the internal reset synchronizer to clear. start_i and pll_lock_i may change at any time: lock passes through the synchronizer, and the properties watch only the order of the control outputs, never when lock arrives. The stimulus changes start_i and pll_lock_i only at falling clock edges and drives start_i as one-cycle pulses. It raises lock either before a run begins or when it sees the retry pulse, so the expected outcome of each round is fixed before that round samples.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ISO, ST_IDDQ, ST_QUIET, ST_CORE, ST_BG, ST_LDO, ST_PWROK,
    ST_PLLEN, ST_UNISO, ST_UNIDDQ, ST_PLLREL, ST_POLL, ST_PULSE, ST_FIN
  } seq_st_e;

  typedef struct packed {
    logic iso;
    logic iddq;
    logic bg_en;
    logic pll_en;
    logic ldo_en;
    logic core_rdy;
    logic pwr_on;
    logic pwr_ok;
    logic pll_rst_n;
    logic phy_rst_n;
  } ctl_t;

  // step waits in microseconds
  localparam int unsigned US_ISO    = 10;
  localparam int unsigned US_IDDQ   = 10;
  localparam int unsigned US_QUIET  = 160;
  localparam int unsigned US_CORE   = 50;
  localparam int unsigned US_BG     = 200;
  localparam int unsigned US_LDO    = 10;
  localparam int unsigned US_PWROK  = 10;
  localparam int unsigned US_PLLEN  = 10;
  localparam int unsigned US_UNISO  = 10;
  localparam int unsigned US_UNIDDQ = 1;
  localparam int unsigned US_POLL   = 1;
  localparam int unsigned US_MAX    = 200;

  localparam ctl_t CTL_OFF = '{iso: 1'b1, default: 1'b0};

endpackage

// File: rtl/sync2.sv
module sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/step_timer.sv
module step_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 4,
  parameter int unsigned LOCK_TRIES = 5,
  parameter int unsigned PCTL_W     = 3,
  parameter logic [PCTL_W-1:0] PCTL_PWRUP = 3'b101,
  parameter logic [PCTL_W-1:0] PCTL_HIZ   = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pll_lock_i,
  output logic              iso_o,
  output logic              iddq_o,
  output logic              bg_en_o,
  output logic              pll_en_o,
  output logic              ldo_en_o,
  output logic              core_rdy_o,
  output logic              pwr_on_o,
  output logic              pwr_ok_o,
  output logic              pll_rst_n_o,
  output logic              phy_rst_n_o,
  output logic [PCTL_W-1:0] pctl_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned CW = $clog2(US_MAX * CYC_PER_US);
  localparam int unsigned TW = (LOCK_TRIES > 1) ? $clog2(LOCK_TRIES) : 1;

  function automatic logic [CW-1:0] dly(input int unsigned us);
    return CW'(us * CYC_PER_US - 1);
  endfunction

  logic rst_q, lock_s, tmr_zero, ld;
  logic [CW-1:0] ld_val;

  seq_st_e st_q, st_d;
  ctl_t    ctl_q, ctl_d;
  logic [PCTL_W-1:0] pctl_q, pctl_d;
  logic [TW-1:0] tries_q, tries_d;
  logic done_q, done_d, err_q, err_d, retry_q, retry_d, miss_q, miss_d;

  sync2 u_rst_sync (.clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_q));
  sync2 u_lock_sync (.clk(clk), .rst_n(rst_q), .d_i(pll_lock_i), .q_o(lock_s));

  step_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_q), .load_i(ld), .load_val_i(ld_val), .zero_o(tmr_zero)
  );

  always_comb begin
    st_d = st_q; ctl_d = ctl_q; pctl_d = pctl_q; tries_d = tries_q;
    done_d = done_q; err_d = err_q; retry_d = retry_q; miss_d = miss_q;
    ld = 1'b0; ld_val = '0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_ISO; ctl_d = CTL_OFF; pctl_d = '0;
        done_d = 1'b0; err_d = 1'b0; retry_d = 1'b0; miss_d = 1'b0;
        ld = 1'b1; ld_val = dly(US_ISO);
      end
      ST_ISO: if (tmr_zero) begin
        st_d = ST_IDDQ; ctl_d.iddq = 1'b1; ld = 1'b1; ld_val = dly(US_IDDQ);
      end
      ST_IDDQ: if (tmr_zero) begin
        st_d = ST_QUIET;
        ctl_d.bg_en = 1'b0; ctl_d.pll_en = 1'b0;
        ctl_d.ldo_en = 1'b0; ctl_d.core_rdy = 1'b0;
        pctl_d = PCTL_PWRUP; ld = 1'b1; ld_val = dly(US_QUIET);
      end
      ST_QUIET: if (tmr_zero) begin
        st_d = ST_CORE; ctl_d.core_rdy = 1'b1; ld = 1'b1; ld_val = dly(US_CORE);
      end
      ST_CORE: if (tmr_zero) begin
        st_d = ST_BG; ctl_d.bg_en = 1'b1; ld = 1'b1; ld_val = dly(US_BG);
      end
      ST_BG: if (tmr_zero) begin
        st_d = ST_LDO; ctl_d.pwr_on = 1'b1; ctl_d.ldo_en = 1'b1;
        ld = 1'b1; ld_val = dly(US_LDO);
      end
      ST_LDO: if (tmr_zero) begin
        st_d = ST_PWROK; ctl_d.pwr_ok = 1'b1; ld = 1'b1; ld_val = dly(US_PWROK);
      end
      ST_PWROK: if (tmr_zero) begin
        st_d = ST_PLLEN; ctl_d.pll_en = 1'b1; ld = 1'b1; ld_val = dly(US_PLLEN);
      end
      ST_PLLEN: if (tmr_zero) begin
        st_d = ST_UNISO; ctl_d.iso = 1'b0; ld = 1'b1; ld_val = dly(US_UNISO);
      end
      ST_UNISO: if (tmr_zero) begin
        st_d = ST_UNIDDQ; ctl_d.iddq = 1'b0; ld = 1'b1; ld_val = dly(US_UNIDDQ);
      end
      ST_UNIDDQ: if (tmr_zero) begin
        st_d = ST_PLLREL; ctl_d.pll_rst_n = 1'b1;
      end
      ST_PLLREL: begin
        st_d = ST_POLL; ctl_d.phy_rst_n = 1'b1; tries_d = '0;
        ld = 1'b1; ld_val = dly(US_POLL);
      end
      ST_POLL: if (tmr_zero) begin
        if (lock_s) begin
          st_d = ST_FIN; pctl_d = PCTL_HIZ;
        end else if (tries_q == TW'(LOCK_TRIES - 1)) begin
          if (!retry_q) begin
            st_d = ST_PULSE; ctl_d.pll_rst_n = 1'b0; retry_d = 1'b1;
          end else begin
            st_d = ST_FIN; pctl_d = PCTL_HIZ; miss_d = 1'b1;
          end
        end else begin
          tries_d = tries_q + 1'b1; ld = 1'b1; ld_val = dly(US_POLL);
        end
      end
      ST_PULSE: begin
        st_d = ST_POLL; ctl_d.pll_rst_n = 1'b1; tries_d = '0;
        ld = 1'b1; ld_val = dly(US_POLL);
      end
      ST_FIN: begin
        st_d = ST_IDLE; done_d = 1'b1; err_d = miss_q;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q <= ST_IDLE; ctl_q <= CTL_OFF; pctl_q <= '0; tries_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0; retry_q <= 1'b0; miss_q <= 1'b0;
    end else begin
      st_q <= st_d; ctl_q <= ctl_d; pctl_q <= pctl_d; tries_q <= tries_d;
      done_q <= done_d; err_q <= err_d; retry_q <= retry_d; miss_q <= miss_d;
    end
  end

  assign iso_o       = ctl_q.iso;
  assign iddq_o      = ctl_q.iddq;
  assign bg_en_o     = ctl_q.bg_en;
  assign pll_en_o    = ctl_q.pll_en;
  assign ldo_en_o    = ctl_q.ldo_en;
  assign core_rdy_o  = ctl_q.core_rdy;
  assign pwr_on_o    = ctl_q.pwr_on;
  assign pwr_ok_o    = ctl_q.pwr_ok;
  assign pll_rst_n_o = ctl_q.pll_rst_n;
  assign phy_rst_n_o = ctl_q.phy_rst_n;
  assign pctl_o      = pctl_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;

  // R4
  ldo_with_pwron_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(ldo_en_o) |-> $rose(pwr_on_o));
  // R4
  iso_after_pll_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(iso_o) |-> pll_en_o);
  // R5
  pll_rst_first_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(phy_rst_n_o) |-> $past(pll_rst_n_o));
  // R7
  retry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($fell(pll_rst_n_o) && phy_rst_n_o) |=> pll_rst_n_o);
  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_q)
    err_o |-> done_o);
  // R9
  hiz_before_done_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(done_o) |-> ($past(pctl_o) == PCTL_HIZ));
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |-> !busy_o);
endmodule

// File: tb/tb_phy_pwrup_seq.sv
module tb_phy_pwrup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CYC = 4;
  localparam int TRIES = 5;
  localparam logic [2:0] PWRUP = 3'b101;
  localparam logic [2:0] HIZ = 3'b010;
  localparam int B_ISO = 0, B_IDDQ = 1, B_BG = 2, B_PLLEN = 3, B_LDO = 4,
                 B_CORE = 5, B_PWRON = 6, B_PWROK = 7, B_PLLRST = 8,
                 B_PHYRST = 9, B_BUSY = 10, B_DONE = 11, B_ERR = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, lock = 1'b0;
  logic iso, iddq, bg, plle, ldo, core, pon, pok, pllr, phyr, busy, done, err;
  logic [2:0] pctl;
  logic [12:0] obs;
  int total = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_pwrup_seq #(.CYC_PER_US(CYC), .LOCK_TRIES(TRIES), .PCTL_W(3),
                  .PCTL_PWRUP(PWRUP), .PCTL_HIZ(HIZ)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pll_lock_i(lock),
    .iso_o(iso), .iddq_o(iddq), .bg_en_o(bg), .pll_en_o(plle), .ldo_en_o(ldo),
    .core_rdy_o(core), .pwr_on_o(pon), .pwr_ok_o(pok), .pll_rst_n_o(pllr),
    .phy_rst_n_o(phyr), .pctl_o(pctl), .busy_o(busy), .done_o(done), .err_o(err)
  );

  assign obs = {err, done, busy, phyr, pllr, pok, pon, core, ldo, plle, bg, iddq, iso};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic wait_for(input int idx, input bit val, output int n);
    n = 0;
    while (obs[idx] !== val && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk_eq("R1", "outputs in reset", int'({obs, pctl}), int'({13'h0001, 3'b000}));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_eq("R1", "outputs after reset", int'({obs, pctl}), int'({13'h0001, 3'b000}));
  endtask

  task automatic t_full_pass();
    int n;
    lock = 1'b1;
    pulse_start();
    chk_eq("R2", "busy after start", int'(busy), 1);
    wait_for(B_IDDQ, 1, n);        chk_eq("R2", "iso->iddq cycles", n, 10*CYC);
    wait_for(B_CORE, 1, n);        chk_eq("R3", "iddq->core cycles", n, 170*CYC);
    chk_eq("R3", "pctl power-up value", int'(pctl), int'(PWRUP));
    wait_for(B_BG, 1, n);          chk_eq("R3", "core->bandgap cycles", n, 50*CYC);
    wait_for(B_LDO, 1, n);         chk_eq("R3", "bandgap->ldo cycles", n, 200*CYC);
    chk_eq("R4", "power-on with ldo", int'(pon), 1);
    wait_for(B_PWROK, 1, n);       chk_eq("R3", "ldo->power-ok cycles", n, 10*CYC);
    wait_for(B_PLLEN, 1, n);       chk_eq("R3", "power-ok->pll enable cycles", n, 10*CYC);
    wait_for(B_ISO, 0, n);         chk_eq("R4", "pll enable->iso release cycles", n, 10*CYC);
    chk_eq("R4", "pll enable at iso release", int'(plle), 1);
    wait_for(B_IDDQ, 0, n);        chk_eq("R4", "iso->iddq release cycles", n, 10*CYC);
    wait_for(B_PLLRST, 1, n);      chk_eq("R5", "iddq->pll reset release", n, CYC);
    wait_for(B_PHYRST, 1, n);      chk_eq("R5", "pll->phy reset release", n, 1);
    wait_for(B_DONE, 1, n);        chk_eq("R6", "phy reset->done on lock", n, CYC + 1);
    chk_eq("R6", "no error on lock", int'(err), 0);
    chk_eq("R9", "pctl non-driving after pass", int'(pctl), int'(HIZ));
    repeat (20) @(negedge clk);
    chk_eq("R11", "done held idle", int'({done, busy}), 2);
  endtask

  task automatic t_busy_start();
    int n;
    lock = 1'b1;
    pulse_start();
    chk_eq("R11", "done cleared by start", int'(done), 0);
    repeat (8) @(negedge clk);
    pulse_start();
    wait_for(B_IDDQ, 1, n);
    chk_eq("R10", "timing unchanged by start while busy", n + 10, 10*CYC);
    wait_for(B_DONE, 1, n);
    chk_eq("R10", "run completes once", int'({done, busy, err}), 4);
  endtask

  task automatic t_retry_pass();
    int n, w;
    lock = 1'b0;
    pulse_start();
    wait_for(B_PHYRST, 1, n);
    wait_for(B_PLLRST, 0, n);
    chk_eq("R6", "polling window before retry", n, TRIES*CYC);
    lock = 1'b1;
    chk_eq("R7", "phy reset held in pulse", int'(phyr), 1);
    wait_for(B_PLLRST, 1, w);
    chk_eq("R7", "retry pulse width", w, 1);
    wait_for(B_DONE, 1, n);
    chk_eq("R7", "retry lock gives no error", int'(err), 0);
  endtask

  task automatic t_fail();
    int n;
    lock = 1'b0;
    pulse_start();
    wait_for(B_PHYRST, 1, n);
    n = 0;
    while (pctl !== HIZ && n < 5000) begin @(negedge clk); n++; end
    chk_eq("R9", "done still low when pctl turns non-driving", int'(done), 0);
    @(negedge clk);
    chk_eq("R8", "done and error after two misses", int'({done, err}), 3);
    chk_eq("R9", "pctl non-driving after fail", int'(pctl), int'(HIZ));
    repeat (30) @(negedge clk);
    chk_eq("R11", "error held idle", int'({done, err, busy}), 6);
    lock = 1'b1;
    pulse_start();
    chk_eq("R11", "error cleared by start", int'({done, err}), 0);
    wait_for(B_DONE, 1, n);
  endtask

  initial begin
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    check(1'b0, "ALL", "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_full_pass();
    t_busy_start();
    t_retry_pass();
    t_fail();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule